// File: doc/BRIEF.md
# Offset Register Sequencer

This block holds the two threshold offsets used by a FIFO's almost-empty and almost-full flag logic. It does not store data and does not compare anything. Each offset is split over a low byte register and a high byte register, so there are four byte-wide slots. With the load strobe low, software walks through the slots one byte per qualified clock edge. Writes happen on the write clock and reads on the read clock. Each side has its own two-bit cyclic slot pointer.

Both pointers follow a fixed slot order and wrap after the fourth slot. A load sequence may stop part-way by raising the load strobe. The next load access resumes at the following slot. The assembled offsets go to the flag logic as plain binary values whose width follows the FIFO depth. The high byte keeps only the bits that width needs, and the rest read back as zero.

Top module: `ofs_access_seq`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets both offsets to 7: each low byte becomes 07h and each high byte becomes 0. It clears both slot pointers to slot code 0 and clears dout to 0.
- R2: A qualified write is a wr_clk rising edge with ld_n low and wr_en_n low. It stores din into the slot selected by the write pointer and advances the pointer. The slot codes are 0 = empty low byte, 1 = empty high byte, 2 = full low byte, 3 = full high byte.
- R3: The write pointer advances cyclically, so the qualified write after slot 3 targets slot 0 again.
- R4: A write edge with ld_n high, or with wr_en_n high, changes no slot and does not move the write pointer. The next qualified write continues at the slot that follows the last one written.
- R5: A qualified read is an rd_clk rising edge with ld_n low and both rd_en1_n and rd_en2_n low. It loads dout with the slot selected by the read pointer, and the new value is visible after that edge. The read pointer then advances in the same cyclic order as writes.
- R6: An rd_clk edge with ld_n high, or with either read enable high, leaves dout and the read pointer unchanged.
- R7: empty_ofs is {empty high byte, empty low byte} and full_ofs is {full high byte, full low byte}, each OFS_W = log2(DEPTH) bits wide. A high byte keeps only its OFS_W-8 low bits. Bits above that, and dout bits at position 8 and up, read as zero.
- R8: The write pointer and the read pointer move independently of each other.
- R9: A qualified write and a qualified read never occur together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_n | input | 1 | Offset access strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | 8 | Byte written into the selected slot |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| dout | output | BUS_W | Slot value returned by a qualified read |
| empty_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| full_ofs | output | OFS_W | Almost-full offset to the flag logic |

## Verification
The clash assertion does not check the design. It states an assumption about the inputs: a qualified write edge never coincides with a qualified read condition. The stimulus meets that assumption by running both ports from one clock and issuing at most one kind of access per cycle. The hold assertions assume that inputs settle away from the clock edge. The bench meets this by driving every input on the falling edge.

// File: rtl/ofs_seq_pkg.sv
package ofs_seq_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned SLOTS  = 4;

   typedef enum logic [1:0] {
      SLOT_E_LO = 2'd0,
      SLOT_E_HI = 2'd1,
      SLOT_F_LO = 2'd2,
      SLOT_F_HI = 2'd3
   } slot_e;

   localparam logic [BYTE_W-1:0] LO_RESET = 8'h07;
endpackage

// File: rtl/ofs_slot_ptr.sv
module ofs_slot_ptr
   import ofs_seq_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  step,
   output slot_e slot
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot <= SLOT_E_LO;
      else if (step) slot <= slot_e'(slot + 2'd1);
   end

   // R3: every qualified access moves one slot on, wrapping after slot 3
   assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (slot == slot_e'($past(slot) + 2'd1)));

   // R4: no access, no movement
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(slot));
endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
   import ofs_seq_pkg::*;
#(
   parameter int unsigned OFS_W = 10
)(
   input  logic                         wr_clk,
   input  logic                         rst_n,
   input  logic                         wr_stb,
   input  slot_e                        wr_slot,
   input  logic [BYTE_W-1:0]            wr_byte,
   output logic [SLOTS-1:0][BYTE_W-1:0] view,
   output logic [OFS_W-1:0]             empty_ofs,
   output logic [OFS_W-1:0]             full_ofs
);
   localparam int unsigned HI_W = OFS_W - BYTE_W;

   logic [1:0][OFS_W-1:0] ofs_pair;

   for (genvar g = 0; g < 2; g++) begin : g_half
      localparam slot_e LO_SLOT = slot_e'(2 * g);
      localparam slot_e HI_SLOT = slot_e'(2 * g + 1);
      logic [BYTE_W-1:0] lo_q;

      always_ff @(posedge wr_clk or negedge rst_n) begin
         if (!rst_n) lo_q <= LO_RESET;
         else if (wr_stb && wr_slot == LO_SLOT) lo_q <= wr_byte;
      end
      assign view[2*g] = lo_q;

      if (HI_W > 0) begin : g_hi
         logic [HI_W-1:0] hi_q;
         always_ff @(posedge wr_clk or negedge rst_n) begin
            if (!rst_n) hi_q <= '0;
            else if (wr_stb && wr_slot == HI_SLOT) hi_q <= HI_W'(wr_byte);
         end
         assign view[2*g+1] = BYTE_W'(hi_q);
         assign ofs_pair[g] = {hi_q, lo_q};
      end else begin : g_no_hi
         assign view[2*g+1] = '0;
         assign ofs_pair[g] = lo_q;
      end
   end

   assign empty_ofs = ofs_pair[0];
   assign full_ofs  = ofs_pair[1];

   // R4: offsets change only on a qualified write
   assert_cfg_hold_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !wr_stb |=> ($stable(empty_ofs) && $stable(full_ofs)));

   // R2: a write into an empty-side slot leaves the full offset alone
   assert_side_sel_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wr_stb && !wr_slot[1]) |=> $stable(full_ofs));
endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
   import ofs_seq_pkg::*;
#(
   parameter int unsigned BUS_W = 9
)(
   input  logic                         rd_clk,
   input  logic                         rst_n,
   input  logic                         rd_stb,
   input  slot_e                        rd_slot,
   input  logic [SLOTS-1:0][BYTE_W-1:0] view,
   output logic [BUS_W-1:0]             dout
);
   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) dout <= '0;
      else if (rd_stb) dout <= BUS_W'(view[rd_slot]);
   end

   // R6: the output register holds without a qualified read
   assert_dout_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !rd_stb |=> $stable(dout));

   // R7: bus bits above the byte stay zero
   assert_upper_zero_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (dout >> BYTE_W) == '0);
endmodule

// File: rtl/ofs_access_seq.sv
module ofs_access_seq
   import ofs_seq_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned BUS_W = 9,
   localparam int unsigned OFS_W = $clog2(DEPTH)
)(
   input  logic              wr_clk,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              ld_n,
   input  logic              wr_en_n,
   input  logic [7:0]        din,
   input  logic              rd_en1_n,
   input  logic              rd_en2_n,
   output logic [BUS_W-1:0]  dout,
   output logic [OFS_W-1:0]  empty_ofs,
   output logic [OFS_W-1:0]  full_ofs
);
   if (DEPTH < 256 || DEPTH > 8192 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two from 256 to 8192");
   end
   if (BUS_W < BYTE_W) begin : g_bad_bus
      $error("BUS_W must be at least one byte");
   end

   logic  wr_stb, rd_stb;
   slot_e wr_slot, rd_slot;
   logic [SLOTS-1:0][BYTE_W-1:0] view;

   assign wr_stb = !ld_n && !wr_en_n;
   assign rd_stb = !ld_n && !rd_en1_n && !rd_en2_n;

   ofs_slot_ptr u_wr_ptr (
      .clk   (wr_clk),
      .rst_n (rst_n),
      .step  (wr_stb),
      .slot  (wr_slot)
   );

   ofs_slot_ptr u_rd_ptr (
      .clk   (rd_clk),
      .rst_n (rst_n),
      .step  (rd_stb),
      .slot  (rd_slot)
   );

   ofs_reg_bank #(.OFS_W(OFS_W)) u_bank (
      .wr_clk    (wr_clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_slot   (wr_slot),
      .wr_byte   (din),
      .view      (view),
      .empty_ofs (empty_ofs),
      .full_ofs  (full_ofs)
   );

   ofs_rd_port #(.BUS_W(BUS_W)) u_rd (
      .rd_clk  (rd_clk),
      .rst_n   (rst_n),
      .rd_stb  (rd_stb),
      .rd_slot (rd_slot),
      .view    (view),
      .dout    (dout)
   );

   // R9: slot writes and slot reads must not coincide
   assert_no_clash_R9: assert property (@(posedge wr_clk) disable iff (!rst_n)
      !(wr_stb && rd_stb));
endmodule

// File: tb/ofs_access_seq_test.sv
module ofs_access_seq_test;
   localparam int unsigned BUS_W = 9;
   localparam int unsigned OFS_W = 10;
   localparam int unsigned NVEC  = 16;

   // op: 0 write, 1 read, 2 ld_n high with enables low, 3 ld_n low with enables high
   // fields: op[38:37] din[36:29] dout[28:20] empty[19:10] full[9:0]
   localparam logic [38:0] VEC [NVEC] = '{
      {2'd0, 8'h21, 9'h000, 10'h021, 10'h007},  // R2 slot 0
      {2'd0, 8'hFE, 9'h000, 10'h221, 10'h007},  // R2 R7 slot 1 keeps 2 bits
      {2'd2, 8'h55, 9'h000, 10'h221, 10'h007},  // R4 ld_n high
      {2'd0, 8'h3C, 9'h000, 10'h221, 10'h03C},  // R4 resume at slot 2
      {2'd3, 8'h99, 9'h000, 10'h221, 10'h03C},  // R4 enable high
      {2'd1, 8'h00, 9'h021, 10'h221, 10'h03C},  // R5 read slot 0
      {2'd1, 8'h00, 9'h002, 10'h221, 10'h03C},  // R5 R7 slot 1
      {2'd3, 8'h00, 9'h002, 10'h221, 10'h03C},  // R6 one enable high
      {2'd2, 8'h00, 9'h002, 10'h221, 10'h03C},  // R6 ld_n high
      {2'd1, 8'h00, 9'h03C, 10'h221, 10'h03C},  // R5 slot 2
      {2'd0, 8'h01, 9'h03C, 10'h221, 10'h13C},  // R2 slot 3
      {2'd1, 8'h00, 9'h001, 10'h221, 10'h13C},  // R5 slot 3
      {2'd0, 8'h80, 9'h001, 10'h280, 10'h13C},  // R3 wrap to slot 0
      {2'd1, 8'h00, 9'h080, 10'h280, 10'h13C},  // R5 R8 read wrap
      {2'd0, 8'h07, 9'h080, 10'h380, 10'h13C},  // R8 write slot 1
      {2'd1, 8'h00, 9'h003, 10'h380, 10'h13C}   // R8 read slot 1
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_n = 1'b1, wr_en_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
   logic [7:0] din = '0;
   logic [BUS_W-1:0] dout;
   logic [OFS_W-1:0] empty_ofs, full_ofs;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ofs_access_seq #(.DEPTH(1024), .BUS_W(BUS_W)) uut (
      .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .ld_n(ld_n),
      .wr_en_n(wr_en_n), .din(din), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
      .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [7:0] d);
      din = d;
      ld_n = 1'b1; wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
      case (op)
         2'd0: begin ld_n = 1'b0; wr_en_n = 1'b0; end
         2'd1: begin ld_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; end
         2'd2: begin wr_en_n = 1'b0; rd_en1_n = 1'b0; end
         default: begin ld_n = 1'b0; rd_en1_n = 1'b0; end
      endcase
   endtask

   task automatic idle();
      ld_n = 1'b1; wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset empty", 32'(empty_ofs), 32'h007);
      chk("R1 reset full", 32'(full_ofs), 32'h007);
      chk("R1 reset dout", 32'(dout), 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i][38:37], VEC[i][36:29]);
         @(posedge clk);
         #2;
         chk($sformatf("R2-R8 vec %0d dout", i), 32'(dout), 32'(VEC[i][28:20]));
         chk($sformatf("R2-R8 vec %0d empty", i), 32'(empty_ofs), 32'(VEC[i][19:10]));
         chk($sformatf("R2-R8 vec %0d full", i), 32'(full_ofs), 32'(VEC[i][9:0]));
      end

      // R1: reset in the middle of a sequence restores defaults and pointers
      @(negedge clk);
      idle();
      rst_n = 1'b0;
      #1;
      chk("R1 mid reset empty", 32'(empty_ofs), 32'h007);
      chk("R1 mid reset full", 32'(full_ofs), 32'h007);
      chk("R1 mid reset dout", 32'(dout), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      @(negedge clk);
      drive(2'd0, 8'hAA);
      @(posedge clk);
      #2;
      chk("R1 write ptr back at slot 0", 32'(empty_ofs), 32'h0AA);
      chk("R1 full untouched", 32'(full_ofs), 32'h007);

      @(negedge clk);
      drive(2'd1, 8'h00);
      @(posedge clk);
      #2;
      chk("R1 R5 read ptr back at slot 0", 32'(dout), 32'h0AA);

      @(negedge clk);
      drive(2'd1, 8'h00);
      @(posedge clk);
      #2;
      chk("R7 default high byte reads zero", 32'(dout), 32'h000);

      @(negedge clk);
      drive(2'd0, 8'hFF);
      @(posedge clk);
      #2;
      chk("R7 high byte truncated", 32'(empty_ofs), 32'h3AA);

      @(negedge clk);
      idle();
      done = 1'b1;
      finish_run();
   end
endmodule